// File: doc/BRIEF.md
# Return Address Stack with Interrupt Gating

This block keeps the return addresses of a small microcontroller core in hardware. A call instruction pushes the address on `push_addr`, a return pops the most recently stored address onto `pop_addr`, and interrupt entry pushes the interrupt return address the same way. The stack holds a fixed number of entries, 16 by default. When a call arrives on a full stack the new address is still stored and the oldest stored address is lost, so the stack always keeps the newest entries.

A small gating stage in front of the stack latches interrupt requests. A pending request is granted only when the stack has a free entry and the core is not issuing a call or a return in that cycle. A grant pushes `push_addr`, clears the pending flag and raises `irq_ack` for one cycle. While the stack is full, the request stays pending and no acknowledge is given. A return frees an entry, and the deferred interrupt is then granted.

Top module: `ras_gate`

## Requirements
- R1: Out of reset `empty` is 1, `full` is 0 and `irq_ack` is 0.
- R2: A return on a non-empty stack puts the most recently stored address on `pop_addr` just after the clock edge that samples `ret_pop`, so addresses come back in reverse push order.
- R3: `full` is 1 exactly when DEPTH entries (16 by default) are held, and `empty` is 1 exactly when none are held. Both flags change just after the clock edge that changes the entry count.
- R4: A call on a full stack stores the new address and drops the oldest one. `full` stays 1, and the following returns give back the newest DEPTH addresses in reverse order.
- R5: An `irq_req` pulse sampled at one edge sets a pending flag. In the next cycle, if the stack is not full and neither `call_push` nor `ret_pop` is high, that edge pushes `push_addr`, clears the flag, and `irq_ack` is 1 for the one cycle after it.
- R6: While the stack is full, a pending request gets no `irq_ack`. After a return frees an entry, the request is granted in the next cycle that has no call or return.
- R7: `call_push` and `ret_pop` together on a non-empty stack output the old top on `pop_addr`, put `push_addr` in its place and leave the entry count unchanged.
- R8: A return on an empty stack leaves `pop_addr`, `empty` and the entry count unchanged.
- R9: A pending request is held, not granted, in any cycle where `call_push` or `ret_pop` is high. The call is stored first and the interrupt address after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_push | input | 1 | Push `push_addr` for a call |
| ret_pop | input | 1 | Pop the top entry for a return |
| push_addr | input | AW (13) | Address to store on a call or on interrupt entry |
| irq_req | input | 1 | Interrupt request, sampled each edge |
| pop_addr | output | AW (13) | Address read by the latest effective pop (registered) |
| full | output | 1 | DEPTH entries held |
| empty | output | 1 | No entries held |
| irq_ack | output | 1 | One-cycle interrupt acknowledge |

## Verification
All results are registered. `pop_addr` updates at the edge that samples the return. `full` and `empty` follow the edge that changes the count. `irq_ack` comes two edges after a request is sampled: one edge latches the request, the next pushes the address. Each extra cycle spent full or busy with a call or return adds one edge to that delay. The driver applies inputs on the falling edge. The monitor takes each expected pop value from the scoreboard queue and compares it 2 ns after the rising edge that samples the return. Flag and acknowledge checks are made on the falling edge after the edge that is meant to produce them, and again one cycle later where a deferral must show no acknowledge.

// File: rtl/ras_pkg.sv
package ras_pkg;
  // Operation applied to the storage in one cycle
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PUSH,
    ST_POP,
    ST_SWAP
  } stk_op_e;
endpackage

// File: rtl/ras_irq_gate.sv
module ras_irq_gate (
  input  logic clk,
  input  logic rst,
  input  logic irq_req,
  input  logic stk_full,
  input  logic call_push,
  input  logic ret_pop,
  output logic grant,
  output logic irq_ack
);
  logic pend_q;

  // Grant only when there is room and the core does not use the stack this cycle
  assign grant = pend_q && !stk_full && !call_push && !ret_pop;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= 1'b0;
      irq_ack <= 1'b0;
    end else begin
      pend_q  <= irq_req || (pend_q && !grant);
      irq_ack <= grant;
    end
  end
endmodule

// File: rtl/ras_store.sv
module ras_store #(
  parameter int DEPTH = 16,
  parameter int AW    = 13,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_en,
  input  logic          pop_en,
  input  logic [AW-1:0] push_addr,
  output logic [AW-1:0] pop_addr,
  output logic [CW-1:0] depth,
  output logic          full,
  output logic          empty
);
  import ras_pkg::*;

  logic [AW-1:0] mem [DEPTH];
  logic [IW-1:0] top_q, top_nxt, top_prv, wr_idx;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] rd_q;
  stk_op_e       op;
  logic          wr_en;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
  assign depth = cnt_q;

  // Circular indexing: an overflowing push simply overwrites the oldest slot
  assign top_nxt = (top_q == IW'(DEPTH - 1)) ? '0 : top_q + 1'b1;
  assign top_prv = (top_q == '0) ? IW'(DEPTH - 1) : top_q - 1'b1;

  always_comb begin
    unique case ({push_en, pop_en})
      2'b10:   op = ST_PUSH;
      2'b01:   op = empty ? ST_IDLE : ST_POP;
      2'b11:   op = empty ? ST_PUSH : ST_SWAP;
      default: op = ST_IDLE;
    endcase
  end

  assign wr_en  = (op == ST_PUSH) || (op == ST_SWAP);
  assign wr_idx = (op == ST_PUSH) ? top_nxt : top_q;

  // Storage array: write port and registered read port, no reset
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= push_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else if ((op == ST_POP) || (op == ST_SWAP)) begin
      rd_q <= mem[top_q];
    end
  end

  assign pop_addr = rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      top_q <= '0;
      cnt_q <= '0;
    end else begin
      unique case (op)
        ST_PUSH: begin
          top_q <= top_nxt;
          if (!full) cnt_q <= cnt_q + 1'b1;
        end
        ST_POP: begin
          top_q <= top_prv;
          cnt_q <= cnt_q - 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ras_gate.sv
module ras_gate #(
  parameter int DEPTH = 16,
  parameter int AW    = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          call_push,
  input  logic          ret_pop,
  input  logic [AW-1:0] push_addr,
  input  logic          irq_req,
  output logic [AW-1:0] pop_addr,
  output logic          full,
  output logic          empty,
  output logic          irq_ack
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          irq_grant;
  logic          push_en;
  logic [CW-1:0] store_depth;

  assign push_en = call_push || irq_grant;

  ras_irq_gate gate_i (
    .clk       (clk),
    .rst       (rst),
    .irq_req   (irq_req),
    .stk_full  (full),
    .call_push (call_push),
    .ret_pop   (ret_pop),
    .grant     (irq_grant),
    .irq_ack   (irq_ack)
  );

  ras_store #(.DEPTH(DEPTH), .AW(AW)) store_i (
    .clk       (clk),
    .rst       (rst),
    .push_en   (push_en),
    .pop_en    (ret_pop),
    .push_addr (push_addr),
    .pop_addr  (pop_addr),
    .depth     (store_depth),
    .full      (full),
    .empty     (empty)
  );
endmodule

// File: rtl/ras_gate_chk.sv
module ras_gate_chk #(
  parameter int DEPTH = 16,
  parameter int AW    = 13,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          call_push,
  input logic          ret_pop,
  input logic          full,
  input logic          empty,
  input logic          irq_ack,
  input logic          irq_grant,
  input logic [AW-1:0] pop_addr,
  input logic [CW-1:0] depth
);
  assert_flags_excl_R3: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

  assert_fill_to_full_R3: assert property (@(posedge clk) disable iff (rst)
    (depth == CW'(DEPTH - 1) && call_push && !ret_pop) |=> full);

  assert_full_kept_R4: assert property (@(posedge clk) disable iff (rst)
    (full && call_push && !ret_pop) |=> full);

  assert_no_ack_when_full_R6: assert property (@(posedge clk) disable iff (rst)
    (full && !ret_pop) |=> !irq_ack);

  assert_swap_depth_R7: assert property (@(posedge clk) disable iff (rst)
    (call_push && ret_pop && !empty) |=> $stable(depth));

  assert_empty_pop_R8: assert property (@(posedge clk) disable iff (rst)
    (empty && ret_pop && !call_push && !irq_grant) |=> (empty && $stable(pop_addr)));

  assert_ack_after_push_R5: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> !empty);
endmodule

bind ras_gate ras_gate_chk #(.DEPTH(DEPTH), .AW(AW)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .call_push (call_push),
  .ret_pop   (ret_pop),
  .full      (full),
  .empty     (empty),
  .irq_ack   (irq_ack),
  .irq_grant (irq_grant),
  .pop_addr  (pop_addr),
  .depth     (store_depth)
);

// File: tb/ras_gate_tb_top.sv
module ras_gate_tb_top;
  localparam int DEPTH = 16;
  localparam int AW    = 13;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          call_push = 1'b0;
  logic          ret_pop = 1'b0;
  logic [AW-1:0] push_addr = '0;
  logic          irq_req = 1'b0;
  logic [AW-1:0] pop_addr;
  logic          full, empty, irq_ack;

  int checks = 0;
  int errors = 0;
  int model[$];
  int exp_q[$];
  logic exp_flag = 1'b0;

  always #5 clk = ~clk;

  ras_gate #(.DEPTH(DEPTH), .AW(AW)) dut_i (
    .clk(clk), .rst(rst), .call_push(call_push), .ret_pop(ret_pop),
    .push_addr(push_addr), .irq_req(irq_req), .pop_addr(pop_addr),
    .full(full), .empty(empty), .irq_ack(irq_ack)
  );

  function automatic void chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endfunction

  // Driver: one cycle of stimulus, scoreboard and model updated alongside
  task automatic step(bit ca, bit rp, bit ir, int a);
    call_push = ca;
    ret_pop   = rp;
    irq_req   = ir;
    push_addr = AW'(a);
    exp_flag  = 1'b0;
    if (rp && model.size() > 0) begin
      exp_q.push_back(model.pop_back());
      exp_flag = 1'b1;
    end
    if (ca) begin
      model.push_back(a);
      if (model.size() > DEPTH) void'(model.pop_front());
    end
    @(negedge clk);
    call_push = 1'b0;
    ret_pop   = 1'b0;
    irq_req   = 1'b0;
    exp_flag  = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drain();
    while (model.size() > 0) step(0, 1, 0, 0);
  endtask

  // Monitor: compares each effective pop with the scoreboard head (R2)
  always @(posedge clk) begin
    if (ret_pop && exp_flag) begin
      int e;
      #2;
      e = exp_q.pop_front();
      chk(pop_addr == AW'(e), "R2 pop order", int'(pop_addr), e);
    end
  end

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int held;
    idle(3);
    // R1 reset state
    chk(empty == 1'b1, "R1 empty", int'(empty), 1);
    chk(full == 1'b0, "R1 full", int'(full), 0);
    chk(irq_ack == 1'b0, "R1 irq_ack", int'(irq_ack), 0);
    rst = 1'b0;
    @(negedge clk);

    // R2 basic LIFO
    step(1, 0, 0, 'h101);
    step(1, 0, 0, 'h0a2);
    step(1, 0, 0, 'h1f3);
    chk(empty == 1'b0, "R3 not empty", int'(empty), 0);
    drain();
    chk(empty == 1'b1, "R3 empty after drain", int'(empty), 1);

    // R8 pop on empty
    held = int'(pop_addr);
    step(0, 1, 0, 'h777);
    chk(int'(pop_addr) == held, "R8 pop_addr held", int'(pop_addr), held);
    chk(empty == 1'b1, "R8 still empty", int'(empty), 1);
    step(1, 0, 0, 'h055);
    step(0, 1, 0, 0);
    chk(empty == 1'b1, "R8 depth unchanged", int'(empty), 1);

    // R7 simultaneous push and pop
    step(1, 0, 0, 'h011);
    step(1, 0, 0, 'h022);
    step(1, 1, 0, 'h033);
    chk(pop_addr == AW'('h022), "R7 swap old top", int'(pop_addr), 'h022);
    step(0, 1, 0, 0);
    step(0, 1, 0, 0);
    chk(empty == 1'b1, "R7 depth kept", int'(empty), 1);

    // R3 fill, R4 overflow
    for (int i = 0; i < DEPTH - 1; i++) step(1, 0, 0, 'h200 + i);
    chk(full == 1'b0, "R3 not full at DEPTH-1", int'(full), 0);
    step(1, 0, 0, 'h2f0);
    chk(full == 1'b1, "R3 full at DEPTH", int'(full), 1);
    step(1, 0, 0, 'h3aa);
    chk(full == 1'b1, "R4 full after overflow", int'(full), 1);
    step(0, 1, 0, 0);
    chk(full == 1'b0, "R3 full clears", int'(full), 0);
    drain();
    chk(empty == 1'b1, "R4 oldest dropped", int'(empty), 1);

    // R5 basic interrupt
    step(0, 0, 1, 'h4c4);
    push_addr = AW'('h4c4);
    chk(irq_ack == 1'b0, "R5 no ack yet", int'(irq_ack), 0);
    @(negedge clk);
    chk(irq_ack == 1'b1, "R5 ack", int'(irq_ack), 1);
    model.push_back('h4c4);
    @(negedge clk);
    chk(irq_ack == 1'b0, "R5 ack one cycle", int'(irq_ack), 0);
    drain();

    // R6 deferral while full
    for (int i = 0; i < DEPTH; i++) step(1, 0, 0, 'h500 + i);
    step(0, 0, 1, 'h6e6);
    push_addr = AW'('h6e6);
    idle(3);
    chk(irq_ack == 1'b0, "R6 held while full", int'(irq_ack), 0);
    chk(full == 1'b1, "R6 still full", int'(full), 1);
    step(0, 1, 0, 'h6e6);
    chk(irq_ack == 1'b0, "R6 no ack in ret cycle", int'(irq_ack), 0);
    @(negedge clk);
    chk(irq_ack == 1'b1, "R6 ack after ret", int'(irq_ack), 1);
    chk(full == 1'b1, "R6 refilled", int'(full), 1);
    model.push_back('h6e6);
    drain();

    // R9 deferral behind a call
    step(0, 0, 1, 'h7d7);
    step(1, 0, 0, 'h0c1);
    chk(irq_ack == 1'b0, "R9 no ack after call", int'(irq_ack), 0);
    push_addr = AW'('h7d7);
    @(negedge clk);
    chk(irq_ack == 1'b1, "R9 ack after call", int'(irq_ack), 1);
    model.push_back('h7d7);
    drain();
    chk(empty == 1'b1, "R9 empty at end", int'(empty), 1);

    idle(2);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule